// File: doc/BRIEF.md
# SPI Slave Byte Engine

This block is the serial end of a byte-wide SPI slave. An external master drives the serial clock, the data line into the slave and an active-low select. The block returns data on its own output line, together with an output-enable that a pad cell uses to release the line. All three serial inputs pass through synchronisers and are oversampled by the fast system clock. Every edge decision is made in the system clock domain. The serial clock must therefore run well below the system clock: a half period of at least four system cycles gives margin.

The host side is a plain register interface. The host writes the next outgoing byte with a one-cycle load strobe. It reads the last completed incoming byte from a holding register. A one-cycle pulse marks each finished byte. A sticky valid flag stays set until the host acknowledges the byte with a read strobe. The clock polarity, the clock phase and the bit order are static inputs. They may change only while select is high.

Top module: `spi_slave_engine`

## Requirements
- R1: `miso_oe` is 0 while select is high and 1 while select is low, each after the synchroniser delay; reset leaves it 0.
- R2: With `cpha`=0 the first outgoing bit is on `miso_out` as soon as select is low, before any clock edge; incoming bits are captured on the leading clock edge and the output advances on the trailing edge.
- R3: With `cpha`=1 the output advances on every leading clock edge except the first of a byte, and incoming bits are captured on the trailing edge.
- R4: `cpol`=0 means the clock idles low, so the leading edge is rising; `cpol`=1 means it idles high, so the leading edge is falling.
- R5: `lsb_first`=0 moves bit 7 first and bit 0 last in both directions; `lsb_first`=1 moves bit 0 first and bit 7 last.
- R6: After the eighth capture the assembled byte appears on `rx_data` together with a `done_pulse` that lasts one cycle; `rx_data` holds until the next completed byte overwrites it.
- R7: `rx_valid` sets with `done_pulse` and stays set until `rx_read`; a completion in the same cycle as `rx_read` leaves it set.
- R8: With `cpha`=0, clock edges after the eighth bit are ignored until select goes high and then low again.
- R9: With `cpha`=1, bytes may follow each other with select held low; each byte takes exactly eight clock cycles.
- R10: Select going high before the eighth capture aborts the byte: no `done_pulse`, and `rx_data` and `rx_valid` are unchanged.
- R11: `tx_load` stores `tx_data` as the next outgoing byte; a byte already in progress is not altered, and the stored value is used from the start of the next byte.
- R12: After reset `rx_data` is 0, and `rx_valid` and `done_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Clock idle level (0 low, 1 high) |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | Bit order (0 MSB first, 1 LSB first) |
| sck_in | input | 1 | Serial clock from the master |
| mosi_in | input | 1 | Serial data from the master |
| ss_n_in | input | 1 | Active-low select from the master |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the serial data pad |
| tx_data | input | DATA_W | Next byte to transmit |
| tx_load | input | 1 | Strobe that stores `tx_data` |
| rx_data | output | DATA_W | Last completed received byte |
| rx_read | input | 1 | Strobe that acknowledges `rx_data` |
| done_pulse | output | 1 | One-cycle marker of a completed byte |
| rx_valid | output | 1 | Sticky flag for an unread byte |

## Verification
If the bit counter or the hold state is wrong, an incorrect number of captures occurs. The port shows this within one byte as a missing, early or extra `done_pulse`. A stale hold state in phase mode 0 turns clocks after the eighth bit into a spurious completion. A wrong shift register shows up as a wrong bit on `miso_out` at the master's next capture edge, or as a wrong `rx_data` at the pulse. A preload that is skipped while deselected makes the first phase-0 bit wrong before any clock edge.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  typedef struct packed {
    logic lead;
    logic trail;
  } sck_evt_t;

  localparam int unsigned SYNC_BITS = 3;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RST_VAL;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
  import spi_slv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cpol,
  input  logic     sck_s,
  input  logic     ss_n_s,
  output logic     sel_active,
  output sck_evt_t evt
);

  logic sck_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign sel_active = ~ss_n_s;
  assign rise = sck_s & ~sck_q;
  assign fall = ~sck_s & sck_q;

  always_comb begin
    evt.lead  = sel_active & (cpol ? fall : rise);
    evt.trail = sel_active & (cpol ? rise : fall);
  end

endmodule

// File: rtl/spi_slv_shifter.sv
module spi_slv_shifter
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_active,
  input  sck_evt_t          evt,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              miso_bit,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d, rx_shifted;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              hold_q, hold_d;
  logic              capture, shift;

  assign capture = sel_active & ~hold_q & (cpha ? evt.trail : evt.lead);
  assign shift   = sel_active & ~hold_q &
                   (cpha ? (evt.lead & (cnt_q != '0)) : evt.trail);

  assign rx_shifted = lsb_first ? {mosi_s, rx_q[DATA_W-1:1]}
                                : {rx_q[DATA_W-2:0], mosi_s};

  assign byte_done = capture & (cnt_q == LAST_IDX);
  assign rx_byte   = rx_shifted;
  assign miso_bit  = lsb_first ? tx_q[0] : tx_q[DATA_W-1];

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    if (!sel_active) begin
      tx_d   = tx_byte;
      rx_d   = '0;
      cnt_d  = '0;
      hold_d = 1'b0;
    end else begin
      if (shift) begin
        tx_d = lsb_first ? (tx_q >> 1) : (tx_q << 1);
      end
      if (capture) begin
        rx_d  = rx_shifted;
        cnt_d = cnt_q + 1'b1;
        if (byte_done) begin
          cnt_d = '0;
          if (cpha) tx_d = tx_byte;
          else      hold_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              sck_in,
  input  logic              mosi_in,
  input  logic              ss_n_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_read,
  output logic              done_pulse,
  output logic              rx_valid
);

  logic [SYNC_BITS-1:0] sync_s;
  logic                 sel_active;
  sck_evt_t             evt;
  logic                 miso_bit, byte_done;
  logic [DATA_W-1:0]    rx_byte;

  logic [DATA_W-1:0] tx_buf_q, tx_buf_d;
  logic [DATA_W-1:0] rx_buf_q, rx_buf_d;
  logic              valid_q, valid_d;
  logic              done_q;

  spi_slv_sync #(
    .WIDTH   (SYNC_BITS),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ss_n_in, sck_in, mosi_in}),
    .sync_out (sync_s)
  );

  spi_slv_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpol       (cpol),
    .sck_s      (sync_s[1]),
    .ss_n_s     (sync_s[2]),
    .sel_active (sel_active),
    .evt        (evt)
  );

  spi_slv_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_active (sel_active),
    .evt        (evt),
    .cpha       (cpha),
    .lsb_first  (lsb_first),
    .mosi_s     (sync_s[0]),
    .tx_byte    (tx_buf_q),
    .miso_bit   (miso_bit),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte)
  );

  always_comb begin
    tx_buf_d = tx_load ? tx_data : tx_buf_q;
    rx_buf_d = byte_done ? rx_byte : rx_buf_q;
    valid_d  = valid_q;
    if (rx_read)   valid_d = 1'b0;
    if (byte_done) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf_q <= '0;
      rx_buf_q <= '0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      tx_buf_q <= tx_buf_d;
      rx_buf_q <= rx_buf_d;
      valid_q  <= valid_d;
      done_q   <= byte_done;
    end
  end

  assign miso_oe    = sel_active;
  assign miso_out   = sel_active & miso_bit;
  assign rx_data    = rx_buf_q;
  assign rx_valid   = valid_q;
  assign done_pulse = done_q;

endmodule

// File: rtl/spi_slave_engine_chk.sv
module spi_slave_engine_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_pulse,
  input logic              rx_valid,
  input logic              rx_read,
  input logic              miso_oe,
  input logic [DATA_W-1:0] rx_data
);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |-> $stable(rx_data));

  p_valid_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> rx_valid);

  p_valid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_read) |=> (!rx_valid || done_pulse));

  p_done_selected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(miso_oe));

endmodule

bind spi_slave_engine spi_slave_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_pulse (done_pulse),
  .rx_valid   (rx_valid),
  .rx_read    (rx_read),
  .miso_oe    (miso_oe),
  .rx_data    (rx_data)
);

// File: tb/spi_slave_engine_test.sv
`timescale 1ns/1ps
module spi_slave_engine_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
  logic       sck_in = 1'b0, mosi_in = 1'b0, ss_n_in = 1'b1;
  logic       miso_out, miso_oe;
  logic [7:0] tx_data = '0;
  logic       tx_load = 1'b0;
  logic [7:0] rx_data;
  logic       rx_read = 1'b0;
  logic       done_pulse, rx_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  spi_slave_engine uut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first),
    .sck_in(sck_in), .mosi_in(mosi_in), .ss_n_in(ss_n_in),
    .miso_out(miso_out), .miso_oe(miso_oe),
    .tx_data(tx_data), .tx_load(tx_load),
    .rx_data(rx_data), .rx_read(rx_read),
    .done_pulse(done_pulse), .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (8) @(negedge clk);
  endtask

  task automatic load_tx(input logic [7:0] v);
    @(negedge clk); tx_data = v; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic ack_rx();
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
  endtask

  task automatic sel_low();
    @(negedge clk); ss_n_in = 1'b0;
    wait_h();
    check(miso_oe === 1'b1, "R1 oe while selected", {7'd0, miso_oe}, 8'd1);
  endtask

  task automatic sel_high();
    wait_h();
    ss_n_in = 1'b1;
    wait_h();
    check(miso_oe === 1'b0, "R1 oe while deselected", {7'd0, miso_oe}, 8'd0);
  endtask

  // master side: drives mosi and sck, samples miso at its capture edge
  task automatic run_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = '0;
    for (int i = 0; i < nbits; i++) begin
      int idx;
      idx = lsb_first ? i : 7 - i;
      if (!cpha) begin
        mosi_in = mo[idx]; wait_h();
        sck_in = ~cpol; mi[idx] = miso_out; wait_h();
        sck_in = cpol;
      end else begin
        sck_in = ~cpol; mosi_in = mo[idx]; wait_h();
        sck_in = cpol; mi[idx] = miso_out; wait_h();
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_pulse) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R8/R10 unexpected done_pulse", rx_data, 8'h00);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rx_data === e, "R6 received byte", rx_data, e);
        check(rx_valid === 1'b1, "R7 valid with done", {7'd0, rx_valid}, 8'd1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, mo, st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(rx_data === 8'h00, "R12 rx_data after reset", rx_data, 8'h00);
    check(rx_valid === 1'b0, "R12 rx_valid after reset", {7'd0, rx_valid}, 8'd0);
    check(done_pulse === 1'b0, "R12 done after reset", {7'd0, done_pulse}, 8'd0);
    check(miso_oe === 1'b0, "R1 oe after reset", {7'd0, miso_oe}, 8'd0);

    // R2 R3 R4 R5: all modes, both bit orders
    for (int m = 0; m < 8; m++) begin
      cpol = m[0]; cpha = m[1]; lsb_first = m[2];
      sck_in = cpol;
      mo = 8'h1D + 8'(m * 37);
      st = 8'hB4 ^ 8'(m * 19);
      load_tx(st);
      wait_h();
      exp_q.push_back(mo);
      sel_low();
      run_bits(mo, 8, got);
      sel_high();
      check(got === st, cpha ? "R3/R4/R5 miso bits" : "R2/R4/R5 miso bits", got, st);
      check(rx_valid === 1'b1, "R7 valid sticky", {7'd0, rx_valid}, 8'd1);
      ack_rx();
      @(negedge clk);
      check(rx_valid === 1'b0, "R7 valid cleared by read", {7'd0, rx_valid}, 8'd0);
    end

    // R10 abort mid-byte (phase 0)
    cpol = 1'b0; cpha = 1'b0; lsb_first = 1'b0; sck_in = 1'b0;
    st = rx_data;
    sel_low();
    run_bits(8'hC3, 4, got);
    sel_high();
    check(rx_data === st, "R10 rx_data after abort", rx_data, st);
    check(rx_valid === 1'b0, "R10 rx_valid after abort", {7'd0, rx_valid}, 8'd0);

    // R8 extra clocks ignored in phase 0, R11 mid-byte load does not alter current byte
    load_tx(8'h5A);
    exp_q.push_back(8'h96);
    sel_low();
    load_tx(8'hE1);
    run_bits(8'h96, 8, got);
    check(got === 8'h5A, "R11 byte in progress unchanged", got, 8'h5A);
    run_bits(8'h3C, 8, got);
    sel_high();
    check(rx_data === 8'h96, "R8 extra clocks ignored", rx_data, 8'h96);
    ack_rx();
    exp_q.push_back(8'h71);
    sel_low();
    run_bits(8'h71, 8, got);
    sel_high();
    check(got === 8'hE1, "R11 loaded byte used next", got, 8'hE1);
    ack_rx();

    // R9 phase 1 back-to-back bytes, second overwrites first (R6), reload uses new tx (R11)
    cpol = 1'b1; cpha = 1'b1; lsb_first = 1'b1; sck_in = 1'b1;
    load_tx(8'h27);
    wait_h();
    exp_q.push_back(8'hA9);
    exp_q.push_back(8'h4E);
    sel_low();
    load_tx(8'hD8);
    run_bits(8'hA9, 8, got);
    check(got === 8'h27, "R9 first byte out", got, 8'h27);
    run_bits(8'h4E, 8, got);
    check(got === 8'hD8, "R9/R11 second byte out", got, 8'hD8);
    sel_high();
    check(rx_data === 8'h4E, "R6 overwrite by later byte", rx_data, 8'h4E);
    check(rx_valid === 1'b1, "R7 valid after two bytes", {7'd0, rx_valid}, 8'd1);

    check(exp_q.size() == 0, "R6 all expected bytes seen", 8'(exp_q.size()), 8'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule